// File: doc/BRIEF.md
# Output-Parked Low-Power Scan Chain

This block is a bank of storage bits that doubles as a serial test chain. In normal operation every bit captures its own functional data input on each clock, and the stored value drives a functional output toward downstream combinational logic. When the scan-enable input is raised, the bits stop capturing and form one shift register instead. Bit 0 takes the external serial input, and the last bit's stored value leaves on the serial output.

While scan-enable is high, the functional outputs do not follow the shifting storage. Each one is pinned to a constant fixed per bit at elaboration time by the parameter vector `PARK_VEC`. The downstream logic therefore sees no toggling during shift and holds one chosen input state for the whole scan period. That state can be picked to minimise leakage. The serial path carries the true stored values at all times.

A test pattern takes `NUM_BITS` shift cycles with scan-enable high, then one capture cycle with scan-enable low.

Top module: `parked_scan_chain`

## Requirements
- R1: A synchronous active-high reset clears every stored bit to 0, so `scanOut` is 0 on the cycle after reset is sampled and, with scan-enable low, `funcOut` is all zeros.
- R2: With scan-enable low, each stored bit loads its `dataIn` bit on the rising edge, and `funcOut` equals the stored vector.
- R3: With scan-enable high, bit 0 loads `scanIn` and bit i (i ≥ 1) loads the stored value of bit i−1 on each rising edge.
- R4: Whenever scan-enable is high, including during reset, `funcOut` equals `PARK_VEC`. Bit i of `PARK_VEC` set to 1 parks output i at 1, and 0 parks it at 0.
- R5: `scanOut` equals the stored value of bit `NUM_BITS`−1 in both modes.
- R6: During continuous shifting, the bit on `scanOut` equals the bit presented on `scanIn` exactly `NUM_BITS` cycles earlier.
- R7: After `NUM_BITS` shift cycles, lowering scan-enable makes `funcOut` show the shifted-in pattern, with the bit shifted in first appearing at the top index. The following capture edge then loads `dataIn`.
- R8: `dataIn` has no effect on the stored state while scan-enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| scanEn | input | 1 | 1 = shift and park the outputs, 0 = normal capture |
| scanIn | input | 1 | Serial input into bit 0 |
| dataIn | input | NUM_BITS | Functional data, one bit per storage bit |
| funcOut | output | NUM_BITS | Functional outputs toward downstream logic |
| scanOut | output | 1 | Serial output from the last bit |

## Verification
The assertions assume that `scanEn`, `scanIn`, `dataIn` and `rst` are stable across each rising edge. They also assume that the chain has at least two bits. The stimulus meets the first assumption by changing every input only at the falling edge. It draws random patterns and random mode sequences from a seeded `$urandom`. Random `dataIn` is applied during shifting so that any leak into the chain shows up. Directed sequences cover reset asserted together with scan-enable, and a full shift-in, shift-out pass followed by a capture.

// File: rtl/parked_scan_pkg.sv
package parked_scan_pkg;
  // Strobes that the mode decoder hands to the storage datapath.
  typedef struct packed {
    logic clearEn;   // synchronous clear of every bit
    logic shiftEn;   // serial shift along the chain
    logic captureEn; // parallel load of functional data
    logic parkEn;    // hold functional outputs at the park vector
  } scanStrobes_t;
endpackage

// File: rtl/parked_scan_ctrl.sv
module parked_scan_ctrl
  import parked_scan_pkg::*;
(
  input  logic         rst,
  input  logic         scanEn,
  output scanStrobes_t strobes
);
  // Reset wins over both load modes; parking depends only on scan-enable.
  always_comb begin
    strobes           = '0;
    strobes.clearEn   = rst;
    strobes.shiftEn   = !rst && scanEn;
    strobes.captureEn = !rst && !scanEn;
    strobes.parkEn    = scanEn;
  end
endmodule

// File: rtl/parked_scan_datapath.sv
module parked_scan_datapath
  import parked_scan_pkg::*;
#(
  parameter int                    NUM_BITS = 8,
  parameter logic [NUM_BITS-1:0]   PARK_VEC = '0
) (
  input  logic                clk,
  input  scanStrobes_t        strobes,
  input  logic                scanIn,
  input  logic [NUM_BITS-1:0] dataIn,
  output logic [NUM_BITS-1:0] storedVec,
  output logic [NUM_BITS-1:0] funcOut,
  output logic                scanOut
);
  localparam int LAST = NUM_BITS - 1;

  // Serial input seen by each bit: external pin for bit 0, neighbour otherwise.
  logic [NUM_BITS-1:0] serialSrc;

  for (genvar i = 0; i < NUM_BITS; i++) begin : g_bit
    if (i == 0) begin : g_head
      assign serialSrc[i] = scanIn;
    end else begin : g_body
      assign serialSrc[i] = storedVec[i-1];
    end

    always_ff @(posedge clk) begin
      if (strobes.clearEn)        storedVec[i] <= 1'b0;
      else if (strobes.shiftEn)   storedVec[i] <= serialSrc[i];
      else if (strobes.captureEn) storedVec[i] <= dataIn[i];
    end

    // Park mux: constant per bit while shifting, stored value otherwise.
    if (PARK_VEC[i]) begin : g_park1
      assign funcOut[i] = storedVec[i] | strobes.parkEn;
    end else begin : g_park0
      assign funcOut[i] = storedVec[i] & ~strobes.parkEn;
    end
  end

  assign scanOut = storedVec[LAST];
endmodule

// File: rtl/parked_scan_chain.sv
module parked_scan_chain
  import parked_scan_pkg::*;
#(
  parameter int                  NUM_BITS = 8,
  parameter logic [NUM_BITS-1:0] PARK_VEC = 8'hA5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                scanEn,
  input  logic                scanIn,
  input  logic [NUM_BITS-1:0] dataIn,
  output logic [NUM_BITS-1:0] funcOut,
  output logic                scanOut
);
  scanStrobes_t        strobes;
  logic [NUM_BITS-1:0] storedVec;

  parked_scan_ctrl u_ctrl (
    .rst     (rst),
    .scanEn  (scanEn),
    .strobes (strobes)
  );

  parked_scan_datapath #(
    .NUM_BITS (NUM_BITS),
    .PARK_VEC (PARK_VEC)
  ) u_dp (
    .clk       (clk),
    .strobes   (strobes),
    .scanIn    (scanIn),
    .dataIn    (dataIn),
    .storedVec (storedVec),
    .funcOut   (funcOut),
    .scanOut   (scanOut)
  );
endmodule

// File: rtl/parked_scan_chain_chk.sv
module parked_scan_chain_chk #(
  parameter int                  NUM_BITS = 8,
  parameter logic [NUM_BITS-1:0] PARK_VEC = '0
) (
  input logic                clk,
  input logic                rst,
  input logic                scanEn,
  input logic                scanIn,
  input logic [NUM_BITS-1:0] dataIn,
  input logic [NUM_BITS-1:0] funcOut,
  input logic                scanOut,
  input logic [NUM_BITS-1:0] storedVec
);
  // R1: the edge after reset leaves every bit cleared
  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (storedVec == '0));

  // R2: capture loads functional data
  assert_capture_load_R2: assert property (@(posedge clk) disable iff (rst)
    $past(!scanEn && !rst) |-> (storedVec == $past(dataIn)));

  // R2: in normal mode the outputs show the stored bits
  assert_func_follow_R2: assert property (@(posedge clk) disable iff (rst)
    !scanEn |-> (funcOut == storedVec));

  // R3 and R8: a shift moves the chain by one and ignores dataIn
  assert_shift_step_R3: assert property (@(posedge clk) disable iff (rst)
    $past(scanEn && !rst) |->
      (storedVec == {$past(storedVec[NUM_BITS-2:0]), $past(scanIn)}));

  // R4: outputs are parked while scanning; checked on every edge, reset included
  always @(posedge clk) begin
    assert_park_hold_R4: assert (!scanEn || funcOut == PARK_VEC);
  end

  // R5: the serial output is the last stored bit
  assert_scan_out_R5: assert property (@(posedge clk) disable iff (rst)
    scanOut == storedVec[NUM_BITS-1]);
endmodule

bind parked_scan_chain parked_scan_chain_chk #(
  .NUM_BITS (NUM_BITS),
  .PARK_VEC (PARK_VEC)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .scanEn    (scanEn),
  .scanIn    (scanIn),
  .dataIn    (dataIn),
  .funcOut   (funcOut),
  .scanOut   (scanOut),
  .storedVec (storedVec)
);

// File: tb/parked_scan_chain_tb.sv
module parked_scan_chain_tb;
  localparam int             N    = 8;
  localparam logic [N-1:0]   PARK = 8'b1010_0110;
  localparam int             WATCHDOG = 100000;

  logic         clk = 1'b0;
  logic         rst, scanEn, scanIn;
  logic [N-1:0] dataIn, funcOut;
  logic         scanOut;

  int total = 0;
  int bad   = 0;
  logic [N-1:0] mdl;   // bench model of the stored bits

  always #2.5 clk = ~clk;   // 200 MHz

  parked_scan_chain #(.NUM_BITS(N), .PARK_VEC(PARK)) u_dut (
    .clk(clk), .rst(rst), .scanEn(scanEn), .scanIn(scanIn),
    .dataIn(dataIn), .funcOut(funcOut), .scanOut(scanOut)
  );

  function automatic logic [N-1:0] expFunc(input logic se, input logic [N-1:0] st);
    return se ? PARK : st;
  endfunction

  function automatic logic [N-1:0] nextState(input logic r, input logic se,
                                             input logic si, input logic [N-1:0] d,
                                             input logic [N-1:0] st);
    if (r)       return '0;
    else if (se) return {st[N-2:0], si};
    else         return d;
  endfunction

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One clock: drive at the falling edge, check combinational outputs, then clock.
  task automatic cycle(input logic r, input logic se, input logic si, input logic [N-1:0] d);
    @(negedge clk);
    rst = r; scanEn = se; scanIn = si; dataIn = d;
    #1;
    if (!r) begin
      check(se ? "R4 parked outputs" : "R2 outputs follow storage",
            funcOut, expFunc(se, mdl));
      check("R5 scanOut is last bit", {{(N-1){1'b0}}, scanOut}, {{(N-1){1'b0}}, mdl[N-1]});
    end else if (se) begin
      check("R4 parked during reset", funcOut, PARK);
    end
    @(posedge clk);
    mdl = nextState(r, se, si, d, mdl);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [N-1:0] pat, pat2, capt;
    void'($urandom(32'd4242));
    mdl = '0;
    rst = 1'b1; scanEn = 1'b0; scanIn = 1'b0; dataIn = '1;

    // R1: reset with capture mode, then check the cleared state
    cycle(1'b1, 1'b0, 1'b0, '1);
    cycle(1'b1, 1'b0, 1'b1, '1);
    @(negedge clk); rst = 1'b0; scanEn = 1'b0; dataIn = '0; #1;
    check("R1 reset clears funcOut", funcOut, '0);
    check("R1 reset clears scanOut", {{(N-1){1'b0}}, scanOut}, '0);

    // R4: reset asserted together with scan-enable
    cycle(1'b0, 1'b0, 1'b0, 8'hFF);
    cycle(1'b1, 1'b1, 1'b1, 8'h3C);
    cycle(1'b0, 1'b0, 1'b0, 8'h00);
    @(negedge clk); #1;
    check("R1 cleared after reset with scan", funcOut, '0);

    // R2: directed captures
    cycle(1'b0, 1'b0, 1'b0, 8'h5A);
    cycle(1'b0, 1'b0, 1'b0, 8'hFF);
    cycle(1'b0, 1'b0, 1'b0, 8'h00);

    // R3, R6, R7, R8: full patterns in and out
    for (int p = 0; p < 6; p++) begin
      pat  = N'($urandom);
      pat2 = N'($urandom);
      capt = N'($urandom);
      for (int k = 0; k < N; k++) cycle(1'b0, 1'b1, pat[N-1-k], N'($urandom));
      @(negedge clk); scanEn = 1'b0; dataIn = capt; #1;
      check("R3 R7 R8 shifted pattern visible at capture", funcOut, pat);
      @(posedge clk); mdl = capt;
      @(negedge clk); #1;
      check("R2 capture after pattern", funcOut, capt);
      // load pat again, then shift it out against pat2
      for (int k = 0; k < N; k++) cycle(1'b0, 1'b1, pat[N-1-k], N'($urandom));
      for (int k = 0; k < N; k++) begin
        @(negedge clk); scanEn = 1'b1; scanIn = pat2[N-1-k]; dataIn = N'($urandom); #1;
        check("R6 scanOut delayed by N", {{(N-1){1'b0}}, scanOut},
              {{(N-1){1'b0}}, pat[N-1-k]});
        check("R4 parked each shift cycle", funcOut, PARK);
        @(posedge clk); mdl = {mdl[N-2:0], pat2[N-1-k]};
      end
      @(negedge clk); scanEn = 1'b0; dataIn = mdl; #1;
      check("R6 second pattern in place", funcOut, pat2);
      @(posedge clk);
    end

    // Random mode mixing against the bench model
    for (int c = 0; c < 400; c++)
      cycle(($urandom % 32) == 0, $urandom % 2, $urandom % 2, N'($urandom));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule